// File: doc/BRIEF.md
# Per-Processor Acceptance-Rate Tracker

This block keeps running request statistics for a group of processors that share memory modules over several buses. For every processor it holds an idle/waiting state, counts the requests the processor has placed and the requests that went through, and publishes an acceptance rate as an unsigned 8-bit binary fraction. The rates are meant as priority inputs for the arbiters that decide memory and bus ownership.

In every cycle each processor presents three one-cycle flags: a new-request strobe, a win flag from the memory-stage arbiter and a grant flag from the bus-stage arbiter. The flags carry no state from one cycle to the next. A request goes through only when both arbitration flags are set in the same cycle. The block also outputs, in the same cycle, the number of processors whose request went through. This count is the effective memory bandwidth of that cycle.

The division is done by one shared sequential divider. It visits the processors in turn, and each rate output holds its value between two visits.

Top module: `acc_rate_tracker`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, both counters of every processor are zero, every `waiting_o` bit is 0, and every rate field reads 8'hFF.
- R2: Processor i is accepted in a cycle only if it has an active request (`waiting_o[i]`=1 or `req_new[i]`=1) and both `mem_win[i]` and `bus_win[i]` are 1 in that cycle. Win flags given to a processor with no active request have no effect.
- R3: An idle processor with `req_new[i]`=1 increments its request counter by one. It becomes waiting unless it is accepted in the same cycle.
- R4: A waiting processor ignores `req_new[i]`. If it is denied, it stays waiting and its request counter does not change.
- R5: An accepted processor increments its accepted counter by one and is idle in the next cycle.
- R6: `bw_count` equals, in the same cycle and combinationally, the number of processors accepted in that cycle.
- R7: The rate field of processor i (bits i*8+7 down to i*8 of `rate_o`) equals min(floor(acc*256/req), 255). A processor with req = 0 reads 255, which stands for a rate of 1.0.
- R8: Both counters saturate at 2^CNT_W-1 and do not wrap.
- R9: The divider visits processors 0..N-1 in order and spends RATE_W+3 cycles on each. Every rate field therefore reflects the counters within 2*N*(RATE_W+3) cycles after they last changed, and it holds its value between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics and states |
| req_new | input | N_PROC | Per-processor new-request strobe |
| mem_win | input | N_PROC | Per-processor memory-stage win flag |
| bus_win | input | N_PROC | Per-processor bus-stage grant flag |
| waiting_o | output | N_PROC | 1 = processor has an outstanding request |
| rate_o | output | N_PROC*RATE_W | Packed acceptance rates, processor i in field i |
| bw_count | output | $clog2(N_PROC+1) | Processors accepted this cycle |

## Verification
A corrupted state bit shows up at once. It changes `waiting_o` at the next clock and shifts `bw_count` in any later cycle that carries win flags. A wrong counter is only visible through the rates, at the next divider visit, up to one full sweep (44 cycles for the default size) later. For this reason the bench lets the divider settle before it compares rates. A counter that wraps instead of saturating is caught with a request count above 255 and a single outstanding request, which gives 250 instead of 255.

// File: rtl/acc_rate_pkg.sv
// Shared types for the acceptance-rate tracker.
package acc_rate_pkg;
    // Phases of the shared sequential divider.
    typedef enum logic [1:0] {
        D_LOAD  = 2'd0,
        D_RUN   = 2'd1,
        D_WRITE = 2'd2
    } div_state_t;
endpackage

// File: rtl/proc_slot.sv
// One processor's request state and saturating statistics.
// Assumes the arbitration flags are valid for the current cycle only.
module proc_slot #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             req_new,
    input  logic             mem_win,
    input  logic             bus_win,
    output logic             waiting,
    output logic             accepted,
    output logic [CNT_W-1:0] req_cnt,
    output logic [CNT_W-1:0] acc_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             waiting_q;
    logic [CNT_W-1:0] req_cnt_q;
    logic [CNT_W-1:0] acc_cnt_q;
    logic             active;

    // Active request this cycle and acceptance decision.
    always_comb begin
        active   = waiting_q | req_new;
        accepted = active & mem_win & bus_win;
    end

    // State and saturating counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            waiting_q <= 1'b0;
            req_cnt_q <= '0;
            acc_cnt_q <= '0;
        end else begin
            if (!waiting_q && req_new && req_cnt_q != CNT_MAX)
                req_cnt_q <= req_cnt_q + 1'b1;
            if (accepted && acc_cnt_q != CNT_MAX)
                acc_cnt_q <= acc_cnt_q + 1'b1;
            waiting_q <= active & ~accepted;
        end
    end

    assign waiting = waiting_q;
    assign req_cnt = req_cnt_q;
    assign acc_cnt = acc_cnt_q;

    a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (req_cnt_q == '0 && acc_cnt_q == '0 && !waiting_q));
    a_r4_denied_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && waiting_q && !(mem_win && bus_win)) |=> (waiting_q && $stable(req_cnt_q)));
    a_r5_accept_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && accepted) |=> !waiting_q);
    a_r8_acc_le_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt_q <= req_cnt_q);
endmodule

// File: rtl/rate_divider.sv
// Shared restoring divider: visits slots in turn, writes min(acc*2^RATE_W/req, max).
// Assumes acc <= req per slot, so RATE_W+1 quotient bits suffice.
module rate_divider
    import acc_rate_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int CNT_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [N_PROC-1:0][CNT_W-1:0]  acc_cnt,
    input  logic [N_PROC-1:0][CNT_W-1:0]  req_cnt,
    output logic [N_PROC*RATE_W-1:0]      rate_o
);
    localparam int IDX_W  = (N_PROC > 1) ? $clog2(N_PROC) : 1;
    localparam int STEP_W = $clog2(RATE_W + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(N_PROC - 1);
    localparam logic [STEP_W-1:0] STEP_TOP  = STEP_W'(RATE_W);

    div_state_t                     state_q;
    logic [IDX_W-1:0]               idx_q;
    logic [STEP_W-1:0]              step_q;
    logic [CNT_W:0]                 rem_q;
    logic [CNT_W-1:0]               den_q;
    logic [RATE_W:0]                quo_q;
    logic [N_PROC-1:0][RATE_W-1:0]  rate_q;

    logic           ge;
    logic [CNT_W:0] diff;
    logic [RATE_W-1:0] result;

    // One restoring step and the saturated result.
    always_comb begin
        ge     = rem_q >= {1'b0, den_q};
        diff   = ge ? (rem_q - {1'b0, den_q}) : rem_q;
        result = (den_q == '0 || quo_q[RATE_W]) ? {RATE_W{1'b1}} : quo_q[RATE_W-1:0];
    end

    // Divider sequencing and rate register updates.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= D_LOAD;
            idx_q   <= '0;
            step_q  <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            quo_q   <= '0;
            rate_q  <= '{default: {RATE_W{1'b1}}};
        end else begin
            case (state_q)
                D_LOAD: begin
                    rem_q   <= {1'b0, acc_cnt[idx_q]};
                    den_q   <= req_cnt[idx_q];
                    quo_q   <= '0;
                    step_q  <= STEP_TOP;
                    state_q <= D_RUN;
                end
                D_RUN: begin
                    quo_q[step_q] <= ge;
                    rem_q         <= {diff[CNT_W-1:0], 1'b0};
                    if (step_q == '0) state_q <= D_WRITE;
                    else              step_q  <= step_q - 1'b1;
                end
                default: begin
                    rate_q[idx_q] <= result;
                    idx_q         <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
                    state_q       <= D_LOAD;
                end
            endcase
        end
    end

    // Flatten the rate registers onto the output bus.
    always_comb begin
        for (int i = 0; i < N_PROC; i++)
            rate_o[i*RATE_W +: RATE_W] = rate_q[i];
    end

    a_r7_zero_den_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == D_WRITE && den_q == '0) |=> rate_q[$past(idx_q)] == {RATE_W{1'b1}});
    a_r9_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == D_RUN && step_q == '0) |=> state_q == D_WRITE);
    a_r9_write_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == D_WRITE) |=> state_q == D_LOAD);
endmodule

// File: rtl/acc_rate_tracker.sv
// Top: per-processor request tracking, per-cycle accepted count, shared rate divider.
// Assumes the win flags come from arbiters that evaluate in the same cycle.
module acc_rate_tracker #(
    parameter int N_PROC = 4,
    parameter int CNT_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [N_PROC-1:0]             req_new,
    input  logic [N_PROC-1:0]             mem_win,
    input  logic [N_PROC-1:0]             bus_win,
    output logic [N_PROC-1:0]             waiting_o,
    output logic [N_PROC*RATE_W-1:0]      rate_o,
    output logic [$clog2(N_PROC+1)-1:0]   bw_count
);
    localparam int BW_W = $clog2(N_PROC + 1);

    logic [N_PROC-1:0]             accepted;
    logic [N_PROC-1:0][CNT_W-1:0]  acc_cnt;
    logic [N_PROC-1:0][CNT_W-1:0]  req_cnt;

    for (genvar g = 0; g < N_PROC; g++) begin : g_slot
        proc_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .req_new  (req_new[g]),
            .mem_win  (mem_win[g]),
            .bus_win  (bus_win[g]),
            .waiting  (waiting_o[g]),
            .accepted (accepted[g]),
            .req_cnt  (req_cnt[g]),
            .acc_cnt  (acc_cnt[g])
        );
    end

    // Count accepted processors this cycle.
    always_comb begin
        bw_count = '0;
        for (int i = 0; i < N_PROC; i++)
            bw_count = bw_count + BW_W'(accepted[i]);
    end

    rate_divider #(.N_PROC(N_PROC), .CNT_W(CNT_W), .RATE_W(RATE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .acc_cnt (acc_cnt),
        .req_cnt (req_cnt),
        .rate_o  (rate_o)
    );

    a_r2_needs_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((accepted & ~(mem_win & bus_win)) == '0));
    a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((accepted & ~(waiting_o | req_new)) == '0));
endmodule

// File: tb/acc_rate_tracker_bench.sv
module acc_rate_tracker_bench;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [N-1:0] req_new = '0, mem_win = '0, bus_win = '0;
    logic [N-1:0] waiting_o;
    logic [N*8-1:0] rate_o;
    logic [2:0] bw_count;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int m_wait[N], m_req[N], m_acc[N];
    logic [15:0] lfsr = 16'hACE1;

    acc_rate_tracker u_acc_rate_tracker (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req_new(req_new),
        .mem_win(mem_win), .bus_win(bus_win), .waiting_o(waiting_o),
        .rate_o(rate_o), .bw_count(bw_count));

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d @%0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] rnd4();
        for (int k = 0; k < 4; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[3:0];
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin m_wait[i] = 0; m_req[i] = 0; m_acc[i] = 0; end
    endtask

    // Drive one cycle, check combinational and registered outputs, advance the model.
    task automatic step(input logic [3:0] rq, input logic [3:0] mw, input logic [3:0] bv, input logic cl);
        int cnt, wv;
        @(negedge clk);
        req_new = rq; mem_win = mw; bus_win = bv; clr = cl;
        #1;
        cnt = 0; wv = 0;
        for (int i = 0; i < N; i++) if (m_wait[i]) wv |= (1 << i);
        chk("R3 R4 waiting", int'(waiting_o), wv);
        if (cl) begin
            model_clear();
        end else begin
            for (int i = 0; i < N; i++) begin
                int act, ac;
                act = m_wait[i] | rq[i];
                ac  = act & mw[i] & bv[i];
                cnt += ac;
                if (!m_wait[i] && rq[i] && m_req[i] < 255) m_req[i]++;
                if (ac && m_acc[i] < 255) m_acc[i]++;
                m_wait[i] = act & !ac;
            end
            chk("R2 R6 bw_count", int'(bw_count), cnt);
        end
    endtask

    task automatic check_rates(input string tag);
        for (int i = 0; i < N; i++) begin
            int e;
            e = (m_req[i] == 0) ? 255 : (m_acc[i] * 256) / m_req[i];
            if (e > 255) e = 255;
            chk(tag, int'(rate_o[i*8 +: 8]), e);
        end
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) step(4'b0, 4'b0, 4'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 waiting after reset", int'(waiting_o), 0);
        check_rates("R1 rate after reset");

        // Random traffic, low grant density (R2..R6)
        for (int k = 0; k < 400; k++) begin
            logic [3:0] a, b, c;
            a = rnd4(); b = rnd4(); c = rnd4();
            step(a, b, c, 1'b0);
        end
        quiet(100);
        check_rates("R7 R9 rate after low-density traffic");

        // Random traffic, high grant density
        for (int k = 0; k < 400; k++) begin
            logic [3:0] a, b, c;
            a = rnd4(); b = rnd4() | rnd4(); c = rnd4() | rnd4();
            step(a, b, c, 1'b0);
        end
        quiet(100);
        check_rates("R7 R9 rate after high-density traffic");
        quiet(30);
        check_rates("R9 rate holds without change");

        // Synchronous clear
        step(4'b0, 4'b0, 4'b0, 1'b1);
        quiet(1);
        check_rates("R1 rate after clear");
        quiet(100);
        check_rates("R1 R7 rate stays full after clear");

        // Directed: proc0 saturates, proc1 gets flags without requesting, proc2 2 of 3
        for (int k = 0; k < 301; k++) begin
            logic [3:0] rq, mw;
            rq = 4'b0001 | ((k < 3) ? 4'b0100 : 4'b0000);
            mw = 4'b0011 | ((k < 2) ? 4'b0100 : 4'b0000);
            step(rq, mw, mw, 1'b0);
        end
        step(4'b0001, 4'b0010, 4'b0010, 1'b0);
        quiet(100);
        // R8 proc0 saturates (wrap would give 250); R7 proc2 = 170; R2 proc1 untouched = 255
        chk("R8 saturated rate proc0", int'(rate_o[7:0]), 255);
        chk("R2 ungranted-idle proc1 rate", int'(rate_o[15:8]), 255);
        chk("R7 proc2 two of three", int'(rate_o[23:16]), 170);
        check_rates("R5 R7 R8 model rates after directed run");
        chk("R4 pending procs wait", int'(waiting_o), 4'b0101);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule